// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Arbiter

This block merges the receive, transmit and break interrupt sources of two serial channels, A and B, into one interrupt request line. The channel datapaths drive it with single-cycle event strobes: a character has arrived, the transmit buffer has drained, or received data has been read. Host commands drive it in the same way: drop the transmit interrupt, or release the interrupt currently under service. Each channel also supplies a break status level and its interrupt-enable fields.

For each channel the block keeps pending and in-service flags for receive and transmit. A receive interrupt takes service ahead of a transmit interrupt. A transmit event that arrives while a receive is in service is held back. It is re-armed once the receive leaves service, either through a data read or through the release command. The block also publishes a pending-bits register and an interrupt vector. The vector is stored as a source code and encoded on the output in one of two layouts, chosen by a status-high select bit.

Top module: `serint_ctrl`

## Requirements
- R1: `irq` is a registered output. One clock after the inputs and state it depends on, it is high exactly when some channel has (TX enable and TX pending), or (RX mode enabled and RX pending), or (break enable and break status high).
- R2: In each 8-bit enable byte, bit 1 enables transmit interrupts. Bits 4:3 select the receive mode: 01 (first character) and 10 (all characters) enable receive interrupts; 00 and 11 do not.
- R3: `pend` bit 0 is B external, bit 1 is B TX, bit 2 is B RX, bit 3 is A external, bit 4 is A TX and bit 5 is A RX. Bits 7:6 read zero. An external bit shows (break enable AND break status), one clock late.
- R4: With `stat_hi` low, `vec` is 0x06 for none, 0x0C for RX A, 0x04 for RX B, 0x08 for TX A and 0x00 for TX B.
- R5: With `stat_hi` high, `vec` is 0x60 for none, 0x30 for RX A, 0x20 for RX B, 0x10 for TX A and 0x00 for TX B. A change of `stat_hi` re-encodes the stored source without a clock.
- R6: A receive strobe sets RX pending, the channel's RX pend bit and RX in-service, and points the vector at that channel's RX.
- R7: A transmit strobe sets TX pending. Only when RX is not in service does it also set TX in-service and point the vector at that channel's TX. It sets the TX pend bit only if TX interrupts are enabled at that moment.
- R8: A data-read pulse clears RX pending, the RX pend bit and RX in-service, and sets the vector to none. It then re-raises TX as in R7 if TX is still pending.
- R9: A release-in-service command clears RX in-service if that is set, and re-raises TX if TX is pending. Otherwise it clears TX in-service.
- R10: A drop-TX command clears TX pending, TX in-service and the TX pend bit, and sets the vector to none. It then re-raises RX as in R6 if RX is pending.
- R11: Within one channel and one cycle, the events apply in this order: data read, drop-TX, release-in-service, receive strobe, transmit strobe. When both channels write the vector in the same cycle, channel A's write is kept.
- R12: After reset, `pend` is 0x00, the vector source is none and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ien_a | input | 8 | Channel A enable byte (bit 1 TX, bits 4:3 RX mode) |
| ien_b | input | 8 | Channel B enable byte |
| brk_ie_a | input | 1 | Channel A break interrupt enable |
| brk_ie_b | input | 1 | Channel B break interrupt enable |
| brk_a | input | 1 | Channel A break status level |
| brk_b | input | 1 | Channel B break status level |
| stat_hi | input | 1 | Selects the status-high vector layout |
| rx_stb_a | input | 1 | Channel A character received |
| rx_stb_b | input | 1 | Channel B character received |
| tx_stb_a | input | 1 | Channel A transmit buffer empty |
| tx_stb_b | input | 1 | Channel B transmit buffer empty |
| rd_a | input | 1 | Channel A received data read |
| rd_b | input | 1 | Channel B received data read |
| cmd_rst_tx_a | input | 1 | Channel A drop-TX command |
| cmd_rst_tx_b | input | 1 | Channel B drop-TX command |
| cmd_rst_ius_a | input | 1 | Channel A release-in-service command |
| cmd_rst_ius_b | input | 1 | Channel B release-in-service command |
| irq | output | 1 | Shared interrupt request |
| pend | output | 8 | Pending-bits register |
| vec | output | 8 | Interrupt vector |

## Verification
The in-service flags never appear at the ports. They show only through what a transmit strobe does afterwards, so the hardest case is a deferred transmit event that is later re-armed. Reaching it takes three steps: a receive strobe to put RX into service, a transmit strobe with TX enabled, which must leave the vector and the TX pend bit alone, and then a release-in-service command or a data read, which must bring the TX vector and pend bit back. Directed sequences set this up on each channel. A long pseudo-random sweep then overlaps strobes, commands and enable changes across both channels, including same-cycle collisions. A model in the bench predicts the pend, vector and irq values after every cycle.

// File: rtl/serint_pkg.sv
// Package: shared types and per-event state transforms for the serial
// interrupt arbiter. Assumes one event of each kind per channel per cycle.
package serint_pkg;

    localparam int REG_W     = 8;
    localparam int NCH       = 2;
    localparam int IE_TX_BIT = 1;
    localparam int IE_RXM_LO = 3;
    localparam int IE_RXM_HI = 4;

    // Vector source as seen by one channel.
    typedef enum logic [1:0] {CV_NONE, CV_RX, CV_TX} chvec_e;

    // Vector source across both channels.
    typedef enum logic [2:0] {VK_NONE, VK_RXA, VK_RXB, VK_TXA, VK_TXB} vkind_e;

    // Per-channel flags: pending, in-service, TX pend bit.
    typedef struct packed {
        logic rxp;
        logic txp;
        logic rxs;
        logic txs;
        logic ptx;
    } chst_t;

    // Intermediate result of applying events in order.
    typedef struct packed {
        chst_t  st;
        logic   vw;
        chvec_e vk;
    } chstep_t;

    function automatic logic rx_mode_on(input logic [1:0] m);
        return (m == 2'b01) || (m == 2'b10);
    endfunction

    function automatic chstep_t raise_rx(input chstep_t s);
        chstep_t r = s;
        r.st.rxp = 1'b1;
        r.st.rxs = 1'b1;
        r.vw     = 1'b1;
        r.vk     = CV_RX;
        return r;
    endfunction

    function automatic chstep_t raise_tx(input chstep_t s, input logic ie);
        chstep_t r = s;
        r.st.txp = 1'b1;
        if (!r.st.rxs) begin
            r.st.txs = 1'b1;
            if (ie) r.st.ptx = 1'b1;
            r.vw = 1'b1;
            r.vk = CV_TX;
        end
        return r;
    endfunction

    function automatic chstep_t drop_rx(input chstep_t s, input logic ie);
        chstep_t r = s;
        r.st.rxp = 1'b0;
        r.st.rxs = 1'b0;
        r.vw     = 1'b1;
        r.vk     = CV_NONE;
        if (r.st.txp) r = raise_tx(r, ie);
        return r;
    endfunction

    function automatic chstep_t drop_tx(input chstep_t s);
        chstep_t r = s;
        r.st.txp = 1'b0;
        r.st.txs = 1'b0;
        r.st.ptx = 1'b0;
        r.vw     = 1'b1;
        r.vk     = CV_NONE;
        if (r.st.rxp) r = raise_rx(r);
        return r;
    endfunction

    function automatic chstep_t release_ius(input chstep_t s, input logic ie);
        chstep_t r = s;
        if (r.st.rxs) begin
            r.st.rxs = 1'b0;
            if (r.st.txp) r = raise_tx(r, ie);
        end else if (r.st.txs) begin
            r.st.txs = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/serint_chan.sv
// Module: one channel's interrupt state. Applies the cycle's events in a
// fixed order (read, drop-TX, release, RX strobe, TX strobe), registers the
// result, and reports its vector write and IRQ term to the top.
// Assumes all event inputs are single-cycle pulses, synchronous to clk.
module serint_chan
    import serint_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] ie,
    input  logic             brk_ie,
    input  logic             brk,
    input  logic             rd,
    input  logic             rst_tx,
    input  logic             rst_ius,
    input  logic             rx_stb,
    input  logic             tx_stb,
    output logic             rxp,
    output logic             ptx,
    output logic             ext,
    output logic             irq_term,
    output logic             vw,
    output chvec_e           vk
);

    chst_t   st_q;
    chstep_t nx;
    logic    ext_q;
    logic    tx_ie;

    assign tx_ie = ie[IE_TX_BIT];

    // Fold this cycle's events into the next state in priority order.
    always_comb begin
        nx.st = st_q;
        nx.vw = 1'b0;
        nx.vk = CV_NONE;
        if (rd)      nx = drop_rx(nx, tx_ie);
        if (rst_tx)  nx = drop_tx(nx);
        if (rst_ius) nx = release_ius(nx, tx_ie);
        if (rx_stb)  nx = raise_rx(nx);
        if (tx_stb)  nx = raise_tx(nx, tx_ie);
    end

    // Hold channel flags and the registered external bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= '0;
            ext_q <= 1'b0;
        end else begin
            st_q  <= nx.st;
            ext_q <= brk_ie & brk;
        end
    end

    // Drive outputs from registered flags and this cycle's vector write.
    always_comb begin
        rxp      = st_q.rxp;
        ptx      = st_q.ptx;
        ext      = ext_q;
        vw       = nx.vw;
        vk       = nx.vk;
        irq_term = (tx_ie & st_q.txp)
                 | (rx_mode_on(ie[IE_RXM_HI:IE_RXM_LO]) & st_q.rxp)
                 | (brk_ie & brk);
    end

    // R7: TX can only be in service while it is pending.
    p_txsvc_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.txs |-> st_q.txp);

    // R6: RX can only be in service while it is pending.
    p_rxsvc_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rxs |-> st_q.rxp);

    // R8: a read without a fresh character leaves RX idle.
    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !rx_stb) |=> !st_q.rxp && !st_q.rxs);

    // R10: drop-TX without a fresh TX strobe leaves TX idle.
    p_droptx_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_tx && !tx_stb) |=> !st_q.txp && !st_q.ptx && !st_q.txs);

    // R7: a TX strobe during RX service touches neither TX service nor pend bit.
    p_tx_deferred_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_stb && st_q.rxs && !rd && !rst_tx && !rst_ius)
        |=> $stable(st_q.txs) && $stable(st_q.ptx));

endmodule

// File: rtl/serint_vecenc.sv
// Module: encodes the stored vector source into the output byte in either
// the low or the status-high layout. Purely combinational.
module serint_vecenc
    import serint_pkg::*;
(
    input  vkind_e           kind,
    input  logic             hi,
    output logic [REG_W-1:0] code
);

    // Select the byte for the source under the current layout.
    always_comb begin
        unique case (kind)
            VK_RXA:  code = hi ? 8'h30 : 8'h0C;
            VK_RXB:  code = hi ? 8'h20 : 8'h04;
            VK_TXA:  code = hi ? 8'h10 : 8'h08;
            VK_TXB:  code = 8'h00;
            default: code = hi ? 8'h60 : 8'h06;
        endcase
    end

endmodule

// File: rtl/serint_ctrl.sv
// Module: top of the dual-channel interrupt arbiter. Instantiates one state
// block per channel (index 0 = A, 1 = B), keeps the shared vector source
// (channel A wins a same-cycle collision), and registers the IRQ line.
// Assumes synchronous pulse inputs and level break/enable inputs.
module serint_ctrl
    import serint_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] ien_a,
    input  logic [REG_W-1:0] ien_b,
    input  logic             brk_ie_a,
    input  logic             brk_ie_b,
    input  logic             brk_a,
    input  logic             brk_b,
    input  logic             stat_hi,
    input  logic             rx_stb_a,
    input  logic             rx_stb_b,
    input  logic             tx_stb_a,
    input  logic             tx_stb_b,
    input  logic             rd_a,
    input  logic             rd_b,
    input  logic             cmd_rst_tx_a,
    input  logic             cmd_rst_tx_b,
    input  logic             cmd_rst_ius_a,
    input  logic             cmd_rst_ius_b,
    output logic             irq,
    output logic [REG_W-1:0] pend,
    output logic [REG_W-1:0] vec
);

    localparam int BITS_PER_CH = 3;

    logic [REG_W-1:0] ie_v   [NCH];
    logic [NCH-1:0]   bie_v, brk_v, rd_v, rtx_v, rius_v, rxs_v, txs_v;
    logic [NCH-1:0]   rxp_v, ptx_v, ext_v, term_v, vw_v;
    chvec_e           vk_v   [NCH];
    vkind_e           vk_q, vk_n;
    logic             irq_q;

    // Gather per-channel inputs into indexed vectors.
    always_comb begin
        ie_v[0] = ien_a;        ie_v[1] = ien_b;
        bie_v   = {brk_ie_b, brk_ie_a};
        brk_v   = {brk_b, brk_a};
        rd_v    = {rd_b, rd_a};
        rtx_v   = {cmd_rst_tx_b, cmd_rst_tx_a};
        rius_v  = {cmd_rst_ius_b, cmd_rst_ius_a};
        rxs_v   = {rx_stb_b, rx_stb_a};
        txs_v   = {tx_stb_b, tx_stb_a};
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        serint_chan u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .ie       (ie_v[c]),
            .brk_ie   (bie_v[c]),
            .brk      (brk_v[c]),
            .rd       (rd_v[c]),
            .rst_tx   (rtx_v[c]),
            .rst_ius  (rius_v[c]),
            .rx_stb   (rxs_v[c]),
            .tx_stb   (txs_v[c]),
            .rxp      (rxp_v[c]),
            .ptx      (ptx_v[c]),
            .ext      (ext_v[c]),
            .irq_term (term_v[c]),
            .vw       (vw_v[c]),
            .vk       (vk_v[c])
        );
    end

    // Pick the vector write for this cycle; channel A overrides B.
    always_comb begin
        vk_n = vk_q;
        if (vw_v[1]) begin
            unique case (vk_v[1])
                CV_RX:   vk_n = VK_RXB;
                CV_TX:   vk_n = VK_TXB;
                default: vk_n = VK_NONE;
            endcase
        end
        if (vw_v[0]) begin
            unique case (vk_v[0])
                CV_RX:   vk_n = VK_RXA;
                CV_TX:   vk_n = VK_TXA;
                default: vk_n = VK_NONE;
            endcase
        end
    end

    // Register the vector source and the combined IRQ.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vk_q  <= VK_NONE;
            irq_q <= 1'b0;
        end else begin
            vk_q  <= vk_n;
            irq_q <= |term_v;
        end
    end

    // Lay out the pending register: B in the low three bits, A above it.
    always_comb begin
        pend = '0;
        for (int c = 0; c < NCH; c++) begin
            pend[(NCH-1-c)*BITS_PER_CH + 0] = ext_v[c];
            pend[(NCH-1-c)*BITS_PER_CH + 1] = ptx_v[c];
            pend[(NCH-1-c)*BITS_PER_CH + 2] = rxp_v[c];
        end
    end

    serint_vecenc u_enc (
        .kind (vk_q),
        .hi   (stat_hi),
        .code (vec)
    );

    assign irq = irq_q;

    // R3: bits above the two channel groups never show a pending source.
    p_pend_top_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pend[REG_W-1:NCH*BITS_PER_CH] == '0);

endmodule

// File: tb/serint_ctrl_test.sv
// Bench: directed sequences plus a long pseudo-random sweep, each cycle
// compared against a behavioural model kept in the bench.
module serint_ctrl_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [7:0] ien [2];
    logic       bie [2], brk [2], rx [2], tx [2], rd [2], rtx [2], rius [2];
    logic       hi;
    logic       irq;
    logic [7:0] pend, vec;

    serint_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .ien_a(ien[0]), .ien_b(ien[1]),
        .brk_ie_a(bie[0]), .brk_ie_b(bie[1]),
        .brk_a(brk[0]), .brk_b(brk[1]),
        .stat_hi(hi),
        .rx_stb_a(rx[0]), .rx_stb_b(rx[1]),
        .tx_stb_a(tx[0]), .tx_stb_b(tx[1]),
        .rd_a(rd[0]), .rd_b(rd[1]),
        .cmd_rst_tx_a(rtx[0]), .cmd_rst_tx_b(rtx[1]),
        .cmd_rst_ius_a(rius[0]), .cmd_rst_ius_b(rius[1]),
        .irq(irq), .pend(pend), .vec(vec)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Model state; vector kind 0 none, 1 RX A, 2 RX B, 3 TX A, 4 TX B.
    logic m_rxp [2], m_txp [2], m_rxs [2], m_txs [2], m_ptx [2], m_ext [2];
    int   m_vk;
    logic e_irq;

    function automatic logic [7:0] vcode(input int k, input logic h);
        case (k)
            1: return h ? 8'h30 : 8'h0C;
            2: return h ? 8'h20 : 8'h04;
            3: return h ? 8'h10 : 8'h08;
            4: return 8'h00;
            default: return h ? 8'h60 : 8'h06;
        endcase
    endfunction

    task automatic m_set_rx(input int c);
        m_rxp[c] = 1; m_rxs[c] = 1; m_vk = (c == 0) ? 1 : 2;
    endtask

    task automatic m_set_tx(input int c);
        m_txp[c] = 1;
        if (!m_rxs[c]) begin
            m_txs[c] = 1;
            if (ien[c][1]) m_ptx[c] = 1;
            m_vk = (c == 0) ? 3 : 4;
        end
    endtask

    task automatic m_clr_rx(input int c);
        m_rxp[c] = 0; m_rxs[c] = 0; m_vk = 0;
        if (m_txp[c]) m_set_tx(c);
    endtask

    task automatic m_clr_tx(input int c);
        m_txp[c] = 0; m_txs[c] = 0; m_ptx[c] = 0; m_vk = 0;
        if (m_rxp[c]) m_set_rx(c);
    endtask

    task automatic m_ius(input int c);
        if (m_rxs[c]) begin
            m_rxs[c] = 0;
            if (m_txp[c]) m_set_tx(c);
        end else if (m_txs[c]) m_txs[c] = 0;
    endtask

    task automatic cmp(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    task automatic clear_pulses();
        for (int c = 0; c < 2; c++) begin
            rx[c] = 0; tx[c] = 0; rd[c] = 0; rtx[c] = 0; rius[c] = 0;
        end
    endtask

    task automatic check_all(input string tag);
        logic [7:0] ep;
        ep = {2'b00, m_rxp[0], m_ptx[0], m_ext[0], m_rxp[1], m_ptx[1], m_ext[1]};
        cmp(tag, "pend", pend, ep);
        cmp(tag, "vec", vec, vcode(m_vk, hi));
        cmp(tag, "irq", {7'd0, irq}, {7'd0, e_irq});
    endtask

    // One clock: predict, apply model events (B first so A's vector wins, R11), compare.
    task automatic step(input string tag);
        logic ni;
        logic ne [2];
        ni = 0;
        for (int c = 0; c < 2; c++) begin
            ni |= (ien[c][1] & m_txp[c])
                | (((ien[c][4:3] == 2'b01) || (ien[c][4:3] == 2'b10)) & m_rxp[c])
                | (bie[c] & brk[c]);
            ne[c] = bie[c] & brk[c];
        end
        for (int c = 1; c >= 0; c--) begin
            if (rd[c])   m_clr_rx(c);
            if (rtx[c])  m_clr_tx(c);
            if (rius[c]) m_ius(c);
            if (rx[c])   m_set_rx(c);
            if (tx[c])   m_set_tx(c);
        end
        @(posedge clk);
        @(negedge clk);
        e_irq = ni;
        m_ext[0] = ne[0];
        m_ext[1] = ne[1];
        check_all(tag);
        clear_pulses();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        hi = 0;
        clear_pulses();
        for (int c = 0; c < 2; c++) begin
            ien[c] = 8'h00; bie[c] = 0; brk[c] = 0;
            m_rxp[c] = 0; m_txp[c] = 0; m_rxs[c] = 0; m_txs[c] = 0;
            m_ptx[c] = 0; m_ext[c] = 0;
        end
        m_vk = 0; e_irq = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        check_all("R12");                       // reset state

        ien[0] = 8'h0A;                         // TX on, RX first-char
        rx[0] = 1; step("R6");                  // pend 0x20, vec 0x0C
        step("R1");                             // irq rises one clock later
        ien[0] = 8'h1A; step("R2");             // mode 11 disables RX term
        step("R2");
        ien[0] = 8'h12; step("R2");             // mode 10 enables again
        step("R1");
        tx[0] = 1; step("R7");                  // deferred: vec and pend unchanged
        rius[0] = 1; step("R9");                // release re-arms TX: vec 0x08
        hi = 1; step("R5");                     // same source, high layout 0x10
        rx[0] = 1; step("R6");
        rd[0] = 1; step("R8");                  // RX gone, TX re-raised
        rtx[0] = 1; step("R10");                // vector none 0x60
        rius[0] = 1; step("R9");                // nothing in service
        hi = 0;
        bie[1] = 1; brk[1] = 1; step("R3");     // ext B one clock late
        step("R3");
        brk[1] = 0; step("R1");
        step("R1");
        ien[1] = 8'h08;
        rx[0] = 1; tx[1] = 1; step("R11");      // A's RX vector wins
        rd[1] = 1; rx[1] = 1; step("R11");      // read then strobe: RX stays
        rtx[1] = 1; tx[1] = 1; step("R11");     // drop then strobe: TX stays
        rd[0] = 1; step("R4");
        rd[1] = 1; step("R4");
        rtx[1] = 1; step("R4");
        rtx[0] = 1; step("R4");
        ien[1] = 8'h00; tx[1] = 1; step("R7");  // TX B, enable off: no pend bit
        rx[1] = 1; step("R4");
        rtx[1] = 1; step("R10");                // RX B re-raised
        hi = 1; step("R5");
        rd[1] = 1; step("R8");

        // Sweep: random events, enables and layout across both channels.
        lf = 32'h1ACE_B00C;
        for (int n = 0; n < 6000; n++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            for (int c = 0; c < 2; c++) begin
                rx[c]   = (lf[c*3 +: 3] == 3'd0);
                tx[c]   = (lf[6 + c*3 +: 3] == 3'd1);
                rd[c]   = (lf[12 + c*3 +: 3] == 3'd2);
                rtx[c]  = (lf[18 + c*3 +: 3] == 3'd3);
                rius[c] = (lf[24 + c*2 +: 2] == 2'd3) && lf[n % 32];
            end
            if ((n % 37) == 0) begin
                ien[0] = {3'b000, lf[3:2], 1'b0, lf[5], 1'b0};
                ien[1] = {3'b000, lf[9:8], 1'b0, lf[11], 1'b0};
                bie[0] = lf[13]; bie[1] = lf[14];
                hi = lf[15];
            end
            brk[0] = lf[28] & lf[29];
            brk[1] = lf[30] & lf[31];
            step("sweep R1 R3 R6 R7 R8 R9 R10 R11");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule